// File: doc/BRIEF.md
# Partitionable Fixed-Point Saturating Lane ALU

This block is the fixed-point datapath of one 64-bit vector lane. A 2-bit width code splits the lane into four 16-bit elements, two 32-bit elements or one 64-bit element. Each element is computed on its own, and no carry, borrow or shifted bit crosses from one element into the next. One opcode applies to every element of the lane. The operations are wrapping and saturating add and subtract, arithmetic right shift with rounding, left shift with saturation, and clamping of each element to half its width.

Each element has its own mask bit. An element whose mask bit is clear is not written. The output register keeps its old contents for that element, and the element sets no flags. For each element the block reports a write enable and a zero flag. It also keeps a saturation flag per element position that stays set until reset. Results appear one clock after the valid strobe.

Top module: `fxp_lane_alu`

## Requirements
- R1: Width code `width_i` selects 16-bit elements for 0, 32-bit elements for 1 and 64-bit elements for 2 or 3. Element e occupies result bits [e*EW +: EW] and uses `mask_i[e]`, `wr_en_o[e]`, `zero_o[e]` and `sat_o[e]`. Flag bits above the element count stay 0. Carries and shifted bits never cross an element boundary.
- R2: Opcode 0 gives a+b and opcode 1 gives a-b, each wrapping modulo 2^EW.
- R3: Opcode 2 gives a+b and opcode 3 gives a-b. On signed overflow the result is clamped to the signed element maximum or minimum, and the element's saturation flag is set.
- R4: Opcode 4 is an arithmetic right shift by `shamt_i` that adds back the most significant discarded bit (round half up). A shift of 0 returns the operand unchanged. A shift of EW or more returns the sign fill.
- R5: Opcode 5 is a left shift by `shamt_i`. If significant bits would be lost, the result is the signed maximum for a non-negative operand or the signed minimum for a negative one, and the saturation flag is set. A shift of EW or more saturates any nonzero operand and gives 0 for a zero operand. A shift of 0 returns the operand.
- R6: Opcode 6 clamps each element of operand a to the signed range of EW/2 bits, sign-extends the result to EW bits, and sets the saturation flag when clamping happens. Opcode 7 passes operand a through unchanged.
- R7: An element whose mask bit is clear is not written. Its `wr_en_o` bit is 0, its result field keeps its previous value, and it cannot set a saturation flag.
- R8: `zero_o[e]` is 1 exactly when element e was written and its new result is zero.
- R9: `sat_o[e]` is sticky. It is set by any written element e that clamps, and only reset clears it.
- R10: `valid_o` follows `valid_i` one clock later, and results and flags change on that same clock. A cycle without valid drives `wr_en_o` and `zero_o` to 0 and leaves `result_o` unchanged.
- R11: Synchronous active-high reset clears `valid_o`, `result_o`, `wr_en_o`, `zero_o` and `sat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| width_i | input | 2 | Element width code |
| op_i | input | 3 | Opcode |
| shamt_i | input | 7 | Shift amount |
| mask_i | input | 4 | Per-element write mask |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Registered lane result |
| wr_en_o | output | 4 | Per-element write enable |
| zero_o | output | 4 | Per-element zero flag |
| sat_o | output | 4 | Sticky per-element saturation flags |

## Verification
Clamping and masking can fall in the same cycle. An element may overflow while its mask bit is clear. The bench drives saturating adds in which every element overflows and the mask selects alternate elements. It then checks three things: the masked-off fields kept their old contents, the sticky flags were set only at the written positions, and a following operation under the complementary mask left those flags as they were. A long run of pseudo-random vectors also mixes widths, opcodes, shift amounts and masks, so clamps and gated elements meet often, and every result is compared against a wide-integer reference model.

// File: rtl/fxp_lane_pkg.sv
package fxp_lane_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_ADDS   = 3'd2,
    OP_SUBS   = 3'd3,
    OP_SRA    = 3'd4,
    OP_SHL    = 3'd5,
    OP_NARROW = 3'd6,
    OP_PASS   = 3'd7
  } fxp_op_e;
endpackage

// File: rtl/fxp_addsub.sv
module fxp_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ax, bx, sum;
  logic       ovf;

  always_comb begin
    ax  = {a[W-1], a};
    bx  = sub ? ~{b[W-1], b} : {b[W-1], b};
    sum = ax + bx + {{W{1'b0}}, sub};
    ovf = sum[W] ^ sum[W-1];
    sat = sat_en & ovf;
    if (sat) res = sum[W] ? SMIN : SMAX;
    else     res = sum[W-1:0];
  end

  // R3: clamping only happens when the operands, after any negation, have the same sign
  always_comb begin
    if (sat) begin
      a_r3_like_signs: assert (a[W-1] == (b[W-1] ^ sub));
    end
  end
endmodule

// File: rtl/fxp_shift.sv
module fxp_shift #(
  parameter int W    = 16,
  parameter int SH_W = 7
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] sh,
  input  logic            left,
  output logic [W-1:0]    res,
  output logic            sat
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic         big;
  logic [W-1:0] shr, t, shl, back;
  logic         rbit, ovf;

  always_comb begin
    big  = ({1'b0, sh} >= (SH_W+1)'(W));
    shr  = $signed(a) >>> sh;
    t    = a >> (sh - 1'b1);
    rbit = (sh != '0) & t[0];
    shl  = a << sh;
    back = $signed(shl) >>> sh;
    ovf  = big ? (a != '0) : (back != a);
    sat  = left & ovf;
    if (left) begin
      if (ovf) res = a[W-1] ? SMIN : SMAX;
      else     res = shl;
    end else begin
      if (big) res = {W{a[W-1]}};
      else     res = shr + {{(W-1){1'b0}}, rbit};
    end
  end

  // R5: an unclamped left shift keeps the operand's sign
  always_comb begin
    if (left && !sat) begin
      a_r5_sign_kept: assert (res == '0 || res[W-1] == a[W-1]);
    end
  end
endmodule

// File: rtl/fxp_elem.sv
module fxp_elem
  import fxp_lane_pkg::*;
#(
  parameter int W    = 16,
  parameter int SH_W = 7
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  fxp_op_e         op,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    res,
  output logic            sat
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] HMAX = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [W-1:0] HMIN = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};

  logic [W-1:0] as_res, sh_res, nr_res;
  logic         as_sat, sh_sat, fits;
  logic [HW:0]  top;

  fxp_addsub #(.W(W)) u_addsub (
    .a(a), .b(b),
    .sub(op == OP_SUB || op == OP_SUBS),
    .sat_en(op == OP_ADDS || op == OP_SUBS),
    .res(as_res), .sat(as_sat)
  );

  fxp_shift #(.W(W), .SH_W(SH_W)) u_shift (
    .a(a), .sh(sh), .left(op == OP_SHL),
    .res(sh_res), .sat(sh_sat)
  );

  always_comb begin
    top    = a[W-1:HW-1];
    fits   = (&top) | ~(|top);
    nr_res = fits ? a : (a[W-1] ? HMIN : HMAX);
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDS, OP_SUBS: begin res = as_res; sat = as_sat; end
      OP_SRA:    begin res = sh_res; sat = 1'b0;   end
      OP_SHL:    begin res = sh_res; sat = sh_sat; end
      OP_NARROW: begin res = nr_res; sat = ~fits;  end
      default:   begin res = a;      sat = 1'b0;   end
    endcase
  end

  // R6: a narrowed element always lies in the half-width signed range
  always_comb begin
    if (op == OP_NARROW) begin
      a_r6_narrow_range: assert ((&res[W-1:HW-1]) || !(|res[W-1:HW-1]));
    end
  end
endmodule

// File: rtl/fxp_lane_alu.sv
module fxp_lane_alu
  import fxp_lane_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int SLOT_W = 16,
  parameter int SH_W   = 7,
  parameter int NSLOT  = LANE_W / SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        width_i,
  input  logic [2:0]        op_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [NSLOT-1:0]  mask_i,
  input  logic [LANE_W-1:0] opa_i,
  input  logic [LANE_W-1:0] opb_i,
  output logic              valid_o,
  output logic [LANE_W-1:0] result_o,
  output logic [NSLOT-1:0]  wr_en_o,
  output logic [NSLOT-1:0]  zero_o,
  output logic [NSLOT-1:0]  sat_o
);
  localparam int NLVL  = $clog2(NSLOT) + 1;
  localparam int LVL_W = (NLVL > 1) ? $clog2(NLVL) : 1;
  localparam int SIDX  = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  fxp_op_e            op;
  logic [LVL_W-1:0]   lvl;
  logic [LANE_W-1:0]  res_l [NLVL];
  logic [NSLOT-1:0]   sat_l [NLVL];
  logic [NSLOT-1:0]   zr_l  [NLVL];
  logic [NSLOT-1:0]   act_l [NLVL];
  logic [LANE_W-1:0]  res_sel;
  logic [NSLOT-1:0]   elem_we, slot_en;

  assign op  = fxp_op_e'(op_i);
  assign lvl = ({{(32-2){1'b0}}, width_i} >= NLVL - 1) ? LVL_W'(NLVL - 1) : LVL_W'(width_i);

  // one bank of element units per element width
  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    localparam int EW = SLOT_W << k;
    localparam int NE = NSLOT >> k;
    for (genvar e = 0; e < NSLOT; e++) begin : g_elem
      if (e < NE) begin : g_on
        logic [EW-1:0] r;
        logic          s;
        fxp_elem #(.W(EW), .SH_W(SH_W)) u_elem (
          .a(opa_i[e*EW +: EW]), .b(opb_i[e*EW +: EW]),
          .op(op), .sh(shamt_i), .res(r), .sat(s)
        );
        assign res_l[k][e*EW +: EW] = r;
        assign sat_l[k][e] = s;
        assign zr_l[k][e]  = ~(|r);
        assign act_l[k][e] = 1'b1;
      end else begin : g_off
        assign sat_l[k][e] = 1'b0;
        assign zr_l[k][e]  = 1'b0;
        assign act_l[k][e] = 1'b0;
      end
    end
  end

  assign res_sel = res_l[lvl];
  assign elem_we = valid_i ? (mask_i & act_l[lvl]) : '0;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SIDX-1:0] eidx;
    assign eidx       = SIDX'(s) >> lvl;
    assign slot_en[s] = elem_we[eidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= '0;
      zero_o   <= '0;
      sat_o    <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= elem_we;
      zero_o  <= elem_we & zr_l[lvl];
      sat_o   <= sat_o | (elem_we & sat_l[lvl]);
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_en[s]) result_o[s*SLOT_W +: SLOT_W] <= res_sel[s*SLOT_W +: SLOT_W];
      end
    end
  end

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> valid_o == $past(valid_i));

  a_r7_mask_gate: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (wr_en_o & ~$past(mask_i)) == '0);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !valid_o) |-> $stable(result_o));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ($past(sat_o) & ~sat_o) == '0);

  a_r8_zero_written: assert property (@(posedge clk) disable iff (rst)
    (zero_o & ~wr_en_o) == '0);

  a_r1_single_elem: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(width_i) >= 2'd2) |-> wr_en_o[NSLOT-1:1] == '0);
endmodule

// File: tb/test_fxp_lane_alu.sv
module test_fxp_lane_alu;
  logic        clk = 0;
  logic        rst = 1;
  logic        valid_i = 0;
  logic [1:0]  width_i = 0;
  logic [2:0]  op_i = 0;
  logic [6:0]  shamt_i = 0;
  logic [3:0]  mask_i = 0;
  logic [63:0] opa_i = 0, opb_i = 0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [3:0]  wr_en_o, zero_o, sat_o;

  always #5 clk = ~clk;

  fxp_lane_alu i_fxp_lane_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .width_i(width_i), .op_i(op_i),
    .shamt_i(shamt_i), .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
    .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .zero_o(zero_o), .sat_o(sat_o)
  );

  typedef struct {
    logic [63:0] res;
    logic [3:0]  we, zero, sat;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_fail = 0;
  logic [63:0] m_res = 0;
  logic [3:0]  m_sat = 0;
  bit          done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [129:0] sx(logic [63:0] x, int ew);
    logic signed [129:0] v;
    v = $signed({66'd0, x});
    v = v <<< (130 - ew);
    v = v >>> (130 - ew);
    return v;
  endfunction

  function automatic logic signed [129:0] clampw(logic signed [129:0] v, int w, output bit s);
    logic signed [129:0] one, lo, hi;
    one = 1;
    lo = -(one <<< (w - 1));
    hi = (one <<< (w - 1)) - 1;
    s = 0;
    if (v > hi) begin s = 1; return hi; end
    if (v < lo) begin s = 1; return lo; end
    return v;
  endfunction

  // reference model of one element, wide signed arithmetic
  function automatic logic [63:0] m_elem(logic [63:0] a, logic [63:0] b, int ew, int op,
                                         int sh, output bit s);
    logic signed [129:0] va, vb, r;
    va = sx(a, ew);
    vb = sx(b, ew);
    s  = 0;
    case (op)
      0: r = va + vb;
      1: r = va - vb;
      2: r = clampw(va + vb, ew, s);
      3: r = clampw(va - vb, ew, s);
      4: begin
        if (sh >= ew)     r = (va < 0) ? -1 : 0;
        else if (sh == 0) r = va;
        else              r = (va >>> sh) + ((va >>> (sh - 1)) & 1);
      end
      5: begin
        if (sh == 0) r = va;
        else if (sh >= ew) begin
          if (va == 0) r = 0;
          else r = clampw((va < 0) ? -(130'sd1 <<< 100) : (130'sd1 <<< 100), ew, s);
        end else r = clampw(va <<< sh, ew, s);
      end
      6: r = clampw(va, ew / 2, s);
      default: r = va;
    endcase
    return r[63:0];
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4:    return "R4";
      5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(string tag, logic [1:0] wc, int op, int sh, logic [3:0] msk,
                       logic [63:0] a, logic [63:0] b);
    exp_t        it;
    int          ew, ne;
    logic [63:0] m, x, y, r;
    bit          s;
    ew = (wc == 0) ? 16 : (wc == 1) ? 32 : 64;
    ne = 64 / ew;
    m  = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    it.we = 0; it.zero = 0;
    for (int e = 0; e < ne; e++) begin
      if (msk[e]) begin
        x = (a >> (e * ew)) & m;
        y = (b >> (e * ew)) & m;
        r = m_elem(x, y, ew, op, sh, s) & m;
        m_res = (m_res & ~(m << (e * ew))) | (r << (e * ew));
        it.we[e] = 1;
        it.zero[e] = (r == 0);
        if (s) m_sat[e] = 1;
      end
    end
    it.res = m_res; it.sat = m_sat; it.tag = tag;
    @(negedge clk);
    q.push_back(it);
    valid_i = 1; width_i = wc; op_i = 3'(op); shamt_i = 7'(sh); mask_i = msk;
    opa_i = a; opb_i = b;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid_i = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; valid_i = 0;
    repeat (3) @(negedge clk);
    q.delete();
    m_res = 0; m_sat = 0;
    rst = 0;
    @(negedge clk);
    chk("R11 valid", 64'(valid_o), 0);
    chk("R11 result", result_o, 0);
    chk("R11 flags", {52'd0, wr_en_o, zero_o, sat_o}, 0);
  endtask

  // monitor: compare every produced result against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10 actual=unexpected valid expected=none");
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(it.tag, result_o, it.res);
          chk("R7 we", 64'(wr_en_o), 64'(it.we));
          chk("R8 zero", 64'(zero_o), 64'(it.zero));
          chk("R9 sat", 64'(sat_o), 64'(it.sat));
        end
      end else begin
        chk("R10 idle we", 64'(wr_en_o | zero_o), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] lf;
    do_reset();
    // R7 / R9: every element overflows, only alternate ones are written
    drive("R7 R3", 2'd0, 2, 0, 4'b0101, 64'h7fff_7fff_7fff_7fff, 64'h0001_0001_0001_0001);
    drive("R9 R7", 2'd0, 0, 0, 4'b1010, 64'h0003_0003_0003_0003, 64'h0001_0001_0001_0001);
    drive("R9", 2'd0, 3, 0, 4'b1000, 64'h8000_0000_0000_0000, 64'h0001_0000_0000_0000);
    idle(3);
    // R10: result holds across idle, then a masked-off write keeps it
    drive("R7 hold", 2'd1, 0, 0, 4'b0000, 64'h1234_5678_9abc_def0, 64'h1);
    // R1: carries stay inside elements
    drive("R1", 2'd0, 0, 0, 4'hf, 64'hffff_7fff_0001_ffff, 64'h0001_0001_ffff_0001);
    drive("R1", 2'd1, 1, 0, 4'hf, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
    drive("R1", 2'd2, 0, 0, 4'hf, 64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001);
    drive("R1", 2'd3, 7, 0, 4'hf, 64'hdead_beef_0bad_f00d, 64'h0);
    drive("R3", 2'd1, 2, 0, 4'h3, 64'h8000_0000_7fff_fff0, 64'h8000_0000_0000_0100);
    drive("R4", 2'd0, 4, 1, 4'hf, 64'hfffb_0005_fffd_0003, 64'h0);
    drive("R4", 2'd0, 4, 0, 4'hf, 64'h8001_7fff_1234_fff1, 64'h0);
    drive("R4", 2'd0, 4, 16, 4'hf, 64'h8001_7fff_1234_fff1, 64'h0);
    drive("R4", 2'd1, 4, 40, 4'h3, 64'h8000_0001_7fff_ffff, 64'h0);
    drive("R5", 2'd1, 5, 1, 4'h3, 64'hc000_0000_4000_0000, 64'h0);
    drive("R5", 2'd1, 5, 40, 4'h3, 64'h0000_0000_0000_0001, 64'h0);
    drive("R5", 2'd2, 5, 4, 4'h1, 64'hf800_0000_0000_0001, 64'h0);
    drive("R6", 2'd0, 6, 0, 4'hf, 64'h0080_ff7f_007f_ff80, 64'h0);
    drive("R6", 2'd2, 6, 0, 4'h1, 64'h0000_0001_0000_0000, 64'h0);
    drive("R8", 2'd0, 1, 0, 4'hf, 64'h1111_2222_3333_4444, 64'h1111_2223_3333_4445);
    idle(3);
    do_reset();
    lf = 64'h9e37_79b9_7f4a_7c15;
    for (int i = 0; i < 400; i++) begin
      int op;
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      op = int'(lf[2:0]);
      drive(op_tag(op), lf[4:3], op, int'(lf[11:5]) % 72, lf[15:12],
            {lf[31:0], lf[63:32]} ^ (lf << 5), lf ^ {lf[7:0], lf[63:8]});
      if (lf[20:18] == 0) idle(2);
    end
    idle(4);
    done = 1;
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 actual=%0d pending expected=0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule